// File: doc/BRIEF.md
# Fixed-Point Euler ODE Integrator

This block integrates four coupled linear differential equations of the form x' = A·x, where A is a constant 4x4 matrix. It uses the explicit Euler method. Each number is a 32-bit signed two's-complement fixed-point value with 8 integer bits and 24 fractional bits, so the range is -128 to just under 128 and one unit in the last place is 2^-24. While the block runs, it completes one full matrix-vector product and one Euler update in every clock cycle. Every value is held in registers.

A host loads the constants through a write port. The constants are the sixteen coefficients, the time step h, the time limit and the step limit. Through the data-input port the host writes the five state slots: the four variables in slots 0 to 3 and the simulation time in slot 4. Writing a slot pauses the solver. A start command clears the step counter and starts the run. When the step counter reaches its limit, the block stops, sets its output word to all ones and allows the slots to be read back one at a time.

The control is a two-state machine:
- HALT: paused. The solver is loading, reading back or finished.
- RUN: stepping.

The transitions are:
- HALT to RUN on the start command.
- RUN to HALT on a slot write, on the restore command, or when the step limit is reached.
- HALT stays in HALT on a restore command, a slot write or a read.
- RUN stays in RUN on a normal step.

Top module: `euler_ode_core`

## Requirements
- R1: Every product is the full 64-bit signed product of two 32-bit operands, arithmetically shifted right by 24 and truncated to 32 bits. Additions wrap modulo 2^32 and nothing saturates.
- R2: The constant at configuration address 4·r+c (0..15) is coefficient A[r][c]. The derivative component r is the wrapped sum over c of A[r][c]·x[c].
- R3: In RUN, each clock that takes a step with t < t_max (signed compare) applies two updates together:
  - each x[i] becomes x[i] + h·x'[i];
  - slot 4 becomes t + h.
- R4: In RUN with t ≥ t_max, slots 0 to 4 keep their values, but the step counter still counts.
- R5: In RUN with the step counter below the step limit (unsigned compare), the counter increments and out_word is 0. On the first clock where the counter is at or above the limit, three things happen:
  - the counter becomes all ones;
  - out_word becomes 0xFFFFFFFF;
  - the block enters HALT.
  After a start with the limit L, out_word therefore reads 0 for L clocks and 0xFFFFFFFF on the clock after that. A limit of 0 gives 0xFFFFFFFF on the first clock after the start.
- R6: In HALT, a clock with out_strobe loads out_word with slot[out_addr]. An address of 5 to 7 loads 0. In RUN, out_strobe has no effect and out_word stays 0. In HALT with no strobe, out_word holds its value.
- R7: A clock with in_strobe has three effects:
  - it writes in_data into slot[in_addr], where an address of 5 to 7 writes nothing;
  - it enters HALT;
  - it sets out_word to 0.
- R8: The restore command (cmd_strobe with cmd_code 2 and cmd_addr 0) clears all five slots, the step counter and out_word, and enters HALT. The constants are kept.
- R9: The start command (cmd_strobe with cmd_code 1 and cmd_addr 0) clears the step counter and out_word, and enters RUN.
- R10: A command with cmd_addr other than 0, or with cmd_code 0 or 3, has no effect.
- R11: When several actions apply in the same clock, they take priority in this order: restore, slot write, start, read, step, finish.
- R12: The synchronous reset, rst high, clears every register and leaves the block in HALT with out_word at 0.
- R13: Configuration address 16 holds h, address 17 holds t_max (signed) and address 18 holds the step limit (unsigned). A write at cfg_we takes effect on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Constant write enable |
| cfg_addr | input | 5 | Constant index: 0..15 matrix, 16 h, 17 t_max, 18 step limit |
| cfg_data | input | 32 | Constant value |
| cmd_strobe | input | 1 | Command qualifier |
| cmd_code | input | 2 | 1 start, 2 restore |
| cmd_addr | input | 3 | Command address, must be 0 |
| in_strobe | input | 1 | Slot write strobe |
| in_addr | input | 3 | Slot index for writes |
| in_data | input | 32 | Slot write data |
| out_strobe | input | 1 | Slot read request |
| out_addr | input | 3 | Slot index for reads |
| out_word | output | 32 | Read data, 0 while running, 0xFFFFFFFF at completion |

## Verification
Some properties are checked on every cycle:
- the restore, start, slot-write and reset outcomes;
- that out_word stays 0 throughout RUN;
- that the counter increments by one or the block halts on each running clock;
- that the block halts with an all-ones word and counter on completion;
- that HALT holds the counter when no strobe is present.

Only the bench scenarios can show the numerical results. These are:
- the matrix product with wrapping;
- the Euler update and the time cap;
- the exact cycle on which completion appears.

The bench scenarios also cover ignored commands, out-of-range addresses and the outcome of conflicting strobes. For these, the bench reads the state slots back through the port and compares them with its own model.

// File: rtl/euler_pkg.sv
package euler_pkg;
    localparam int WORD_W  = 32;
    localparam int FRAC_W  = 24;
    localparam int N_VAR   = 4;
    localparam int CMD_W   = 2;

    localparam logic [CMD_W-1:0] CMD_START   = 2'd1;
    localparam logic [CMD_W-1:0] CMD_RESTORE = 2'd2;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/euler_fxmul.sv
module euler_fxmul #(
    parameter int W = 32,
    parameter int F = 24
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] p
);
    logic signed [2*W-1:0] a_ext;
    logic signed [2*W-1:0] b_ext;
    logic signed [2*W-1:0] full;

    assign a_ext = {{W{a[W-1]}}, a};
    assign b_ext = {{W{b[W-1]}}, b};
    assign full  = a_ext * b_ext;
    // scale back to the operand format, wrap on overflow
    assign p     = W'(full >>> F);
endmodule

// File: rtl/euler_deriv.sv
module euler_deriv #(
    parameter int W = 32,
    parameter int F = 24,
    parameter int N = 4
) (
    input  logic [N*N-1:0][W-1:0] coef,
    input  logic [N-1:0][W-1:0]   x,
    output logic [N-1:0][W-1:0]   d
);
    logic [W-1:0] prod [N][N];

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            euler_fxmul #(.W(W), .F(F)) u_mul (
                .a(coef[r*N+c]),
                .b(x[c]),
                .p(prod[r][c])
            );
        end
    end

    always_comb begin
        for (int r = 0; r < N; r++) begin
            logic [W-1:0] acc;
            acc = '0;
            for (int c = 0; c < N; c++) begin
                acc = acc + prod[r][c];
            end
            d[r] = acc;
        end
    end
endmodule

// File: rtl/euler_step.sv
module euler_step #(
    parameter int W = 32,
    parameter int F = 24,
    parameter int N = 4
) (
    input  logic [N-1:0][W-1:0] x,
    input  logic [N-1:0][W-1:0] d,
    input  logic [W-1:0]        t,
    input  logic [W-1:0]        h,
    input  logic [W-1:0]        t_max,
    output logic [N-1:0][W-1:0] x_next,
    output logic [W-1:0]        t_next
);
    logic [N-1:0][W-1:0] hd;
    logic                advance;

    assign advance = $signed(t) < $signed(t_max);

    for (genvar i = 0; i < N; i++) begin : g_var
        euler_fxmul #(.W(W), .F(F)) u_hmul (
            .a(h),
            .b(d[i]),
            .p(hd[i])
        );
        assign x_next[i] = advance ? (x[i] + hd[i]) : x[i];
    end

    assign t_next = advance ? (t + h) : t;
endmodule

// File: rtl/euler_ctrl.sv
module euler_ctrl
    import euler_pkg::*;
#(
    parameter int W = 32,
    parameter int N = 4,
    parameter int AW = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_strobe,
    input  logic [CMD_W-1:0]     cmd_code,
    input  logic [AW-1:0]        cmd_addr,
    input  logic                 in_strobe,
    input  logic [AW-1:0]        in_addr,
    input  logic [W-1:0]         in_data,
    input  logic                 out_strobe,
    input  logic [AW-1:0]        out_addr,
    input  logic [W-1:0]         step_limit,
    input  logic [N-1:0][W-1:0]  x_next,
    input  logic [W-1:0]         t_next,
    output logic [N-1:0][W-1:0]  x_cur,
    output logic [W-1:0]         t_cur,
    output logic [W-1:0]         out_word,
    output logic                 halted,
    output logic [W-1:0]         step_cnt
);
    localparam int N_SLOT = N + 1;

    run_state_e   state_q, state_d;
    logic [W-1:0] slot_q [N_SLOT];
    logic [W-1:0] step_q;
    logic [W-1:0] out_q;

    logic restore_cmd, start_cmd, limit_hit, wr_ok, rd_ok;

    assign restore_cmd = cmd_strobe && (cmd_addr == '0) && (cmd_code == CMD_RESTORE);
    assign start_cmd   = cmd_strobe && (cmd_addr == '0) && (cmd_code == CMD_START);
    assign limit_hit   = step_q >= step_limit;
    assign wr_ok       = int'(in_addr) < N_SLOT;
    assign rd_ok       = int'(out_addr) < N_SLOT;

    // next-state decision, priority restore > load > start > run/finish
    always_comb begin
        state_d = state_q;
        if (restore_cmd || in_strobe) begin
            state_d = ST_HALT;
        end else if (start_cmd) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_HALT: state_d = ST_HALT;
                ST_RUN:  state_d = limit_hit ? ST_HALT : ST_RUN;
                default: state_d = ST_HALT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HALT;
        else     state_q <= state_d;
    end

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (rst || restore_cmd) begin
            for (int i = 0; i < N_SLOT; i++) slot_q[i] <= '0;
            step_q <= '0;
            out_q  <= '0;
        end else if (in_strobe) begin
            if (wr_ok) slot_q[in_addr] <= in_data;
            out_q <= '0;
        end else if (start_cmd) begin
            step_q <= '0;
            out_q  <= '0;
        end else begin
            unique case (state_q)
                ST_HALT: begin
                    if (out_strobe) out_q <= rd_ok ? slot_q[out_addr] : '0;
                end
                ST_RUN: begin
                    if (!limit_hit) begin
                        for (int i = 0; i < N; i++) slot_q[i] <= x_next[i];
                        slot_q[N] <= t_next;
                        step_q    <= step_q + 1'b1;
                        out_q     <= '0;
                    end else begin
                        step_q <= '1;
                        out_q  <= '1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) x_cur[i] = slot_q[i];
    end
    assign t_cur    = slot_q[N];
    assign out_word = out_q;
    assign halted   = (state_q == ST_HALT);
    assign step_cnt = step_q;
endmodule

// File: rtl/euler_ode_core.sv
module euler_ode_core
    import euler_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int F = FRAC_W,
    parameter int N = N_VAR,
    parameter int AW = $clog2(N + 1),
    parameter int CAW = $clog2(N * N + 3)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CAW-1:0]   cfg_addr,
    input  logic [W-1:0]     cfg_data,
    input  logic             cmd_strobe,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic [AW-1:0]    cmd_addr,
    input  logic             in_strobe,
    input  logic [AW-1:0]    in_addr,
    input  logic [W-1:0]     in_data,
    input  logic             out_strobe,
    input  logic [AW-1:0]    out_addr,
    output logic [W-1:0]     out_word
);
    localparam int N_COEF   = N * N;
    localparam int CA_H     = N_COEF;
    localparam int CA_TMAX  = N_COEF + 1;
    localparam int CA_LIMIT = N_COEF + 2;

    logic [N_COEF-1:0][W-1:0] coef_q;
    logic [W-1:0]             h_q, tmax_q, limit_q;

    logic [N-1:0][W-1:0] x_cur, x_nxt, deriv;
    logic [W-1:0]        t_cur, t_nxt;
    logic                halted;
    logic [W-1:0]        step_cnt;

    // constant registers
    always_ff @(posedge clk) begin
        if (rst) begin
            coef_q  <= '0;
            h_q     <= '0;
            tmax_q  <= '0;
            limit_q <= '0;
        end else if (cfg_we) begin
            for (int k = 0; k < N_COEF; k++) begin
                if (int'(cfg_addr) == k) coef_q[k] <= cfg_data;
            end
            if (int'(cfg_addr) == CA_H)     h_q     <= cfg_data;
            if (int'(cfg_addr) == CA_TMAX)  tmax_q  <= cfg_data;
            if (int'(cfg_addr) == CA_LIMIT) limit_q <= cfg_data;
        end
    end

    euler_deriv #(.W(W), .F(F), .N(N)) u_deriv (
        .coef(coef_q),
        .x(x_cur),
        .d(deriv)
    );

    euler_step #(.W(W), .F(F), .N(N)) u_step (
        .x(x_cur),
        .d(deriv),
        .t(t_cur),
        .h(h_q),
        .t_max(tmax_q),
        .x_next(x_nxt),
        .t_next(t_nxt)
    );

    euler_ctrl #(.W(W), .N(N), .AW(AW)) u_ctrl (
        .clk(clk),
        .rst(rst),
        .cmd_strobe(cmd_strobe),
        .cmd_code(cmd_code),
        .cmd_addr(cmd_addr),
        .in_strobe(in_strobe),
        .in_addr(in_addr),
        .in_data(in_data),
        .out_strobe(out_strobe),
        .out_addr(out_addr),
        .step_limit(limit_q),
        .x_next(x_nxt),
        .t_next(t_nxt),
        .x_cur(x_cur),
        .t_cur(t_cur),
        .out_word(out_word),
        .halted(halted),
        .step_cnt(step_cnt)
    );
endmodule

// File: rtl/euler_ode_chk.sv
module euler_ode_chk
    import euler_pkg::*;
#(
    parameter int W = 32,
    parameter int AW = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_strobe,
    input logic [CMD_W-1:0] cmd_code,
    input logic [AW-1:0]    cmd_addr,
    input logic             in_strobe,
    input logic [W-1:0]     out_word,
    input logic             halted,
    input logic [W-1:0]     step_cnt
);
    logic restore_c, start_c;
    assign restore_c = cmd_strobe && (cmd_addr == '0) && (cmd_code == CMD_RESTORE);
    assign start_c   = cmd_strobe && (cmd_addr == '0) && (cmd_code == CMD_START);

    // R12
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> halted && out_word == '0 && step_cnt == '0);

    // R8
    restore_chk: assert property (@(posedge clk) disable iff (rst)
        restore_c |=> halted && out_word == '0 && step_cnt == '0);

    // R9
    start_chk: assert property (@(posedge clk) disable iff (rst)
        start_c && !in_strobe |=> !halted && out_word == '0 && step_cnt == '0);

    // R7
    load_pause_chk: assert property (@(posedge clk) disable iff (rst)
        in_strobe && !restore_c |=> halted && out_word == '0);

    // R5
    done_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(halted) && !$past(in_strobe) && !$past(restore_c)
        |-> out_word == '1 && step_cnt == '1);

    // R5
    count_chk: assert property (@(posedge clk) disable iff (rst)
        !halted && !cmd_strobe && !in_strobe
        |=> halted || step_cnt == $past(step_cnt) + 1'b1);

    // R6
    run_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !halted |-> out_word == '0);

    // R6
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        halted && !cmd_strobe && !in_strobe |=> halted && $stable(step_cnt));
endmodule

bind euler_ode_core euler_ode_chk #(.W(W), .AW(AW)) u_chk (
    .clk(clk),
    .rst(rst),
    .cmd_strobe(cmd_strobe),
    .cmd_code(cmd_code),
    .cmd_addr(cmd_addr),
    .in_strobe(in_strobe),
    .out_word(out_word),
    .halted(halted),
    .step_cnt(step_cnt)
);

// File: tb/sim_euler_ode_core.sv
`timescale 1ns/1ps
module sim_euler_ode_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_data = '0;
    logic        cmd_strobe = 1'b0;
    logic [1:0]  cmd_code = '0;
    logic [2:0]  cmd_addr = '0;
    logic        in_strobe = 1'b0;
    logic [2:0]  in_addr = '0;
    logic [31:0] in_data = '0;
    logic        out_strobe = 1'b0;
    logic [2:0]  out_addr = '0;
    logic [31:0] out_word;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    euler_ode_core u0 (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .cmd_strobe(cmd_strobe), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
        .in_strobe(in_strobe), .in_addr(in_addr), .in_data(in_data),
        .out_strobe(out_strobe), .out_addr(out_addr), .out_word(out_word)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [31:0] x0, x1, x2, x3, h, tmax, n;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{2'd0, 32'h07000000, 32'h05000000, 32'h07000000, 32'h05000000,
          32'h00004000, 32'h7F000000, 32'd20},
        '{2'd1, 32'h01000000, 32'hFE000000, 32'h03000000, 32'hFC000000,
          32'h00100000, 32'h00400000, 32'd10},
        '{2'd0, 32'hFC800000, 32'h02400000, 32'h00000001, 32'hFFFFFFFF,
          32'h00200000, 32'h7F000000, 32'd8},
        '{2'd1, 32'h00123456, 32'hFF800000, 32'h00000100, 32'h10000000,
          32'h00100000, 32'hFF000000, 32'd5}
    };

    logic [31:0] exp_s [5];

    function automatic logic [31:0] coef(input int sel, input int r, input int c);
        int m0 [16] = '{2, 3, 2, 0, -5, -5, -3, 1, 3, -1, -2, -3, 4, 2, 2, -3};
        if (sel == 0) return 32'(m0[r*4+c] * (1 << 24));
        if (r == c) return 32'hFF000000;
        if (c == (r + 1) % 4) return 32'h00400000;
        return 32'h0;
    endfunction

    function automatic logic [31:0] fmul(input logic [31:0] a, input logic [31:0] b);
        longint p;
        p = longint'($signed(a)) * longint'($signed(b));
        return 32'(p >>> 24);
    endfunction

    task automatic model(input int sel, input logic [31:0] x0, x1, x2, x3,
                         input logic [31:0] h, tmax, input int n);
        logic [31:0] x [4];
        logic [31:0] d [4];
        logic [31:0] t;
        x[0] = x0; x[1] = x1; x[2] = x2; x[3] = x3; t = '0;
        for (int s = 0; s < n; s++) begin
            if ($signed(t) < $signed(tmax)) begin
                for (int r = 0; r < 4; r++) begin
                    d[r] = '0;
                    for (int c = 0; c < 4; c++) d[r] = d[r] + fmul(coef(sel, r, c), x[c]);
                end
                for (int r = 0; r < 4; r++) x[r] = x[r] + fmul(h, d[r]);
                t = t + h;
            end
        end
        for (int i = 0; i < 4; i++) exp_s[i] = x[i];
        exp_s[4] = t;
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic cfg_wr(input int a, input logic [31:0] v);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_data = v;
        tick;
        cfg_we = 1'b0;
    endtask

    task automatic cmd(input logic [1:0] code, input logic [2:0] a);
        cmd_strobe = 1'b1; cmd_code = code; cmd_addr = a;
        tick;
        cmd_strobe = 1'b0;
    endtask

    task automatic in_wr(input int a, input logic [31:0] v);
        in_strobe = 1'b1; in_addr = 3'(a); in_data = v;
        tick;
        in_strobe = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        out_strobe = 1'b1; out_addr = 3'(a);
        tick;
        out_strobe = 1'b0;
        v = out_word;
    endtask

    task automatic load_cfg(input int sel, input logic [31:0] h, tmax, n);
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) cfg_wr(r*4+c, coef(sel, r, c));
        cfg_wr(16, h);
        cfg_wr(17, tmax);
        cfg_wr(18, n);
    endtask

    task automatic load_x(input logic [31:0] x0, x1, x2, x3);
        in_wr(0, x0); in_wr(1, x1); in_wr(2, x2); in_wr(3, x3); in_wr(4, 32'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12: reset state
        chk("R12 out after reset", out_word, 32'h0);
        rd(0, v); chk("R12 slot0 after reset", v, 32'h0);
        rd(4, v); chk("R12 time after reset", v, 32'h0);

        // table-driven scenarios: R1 R2 R3 R4 R5 R9 R13
        for (int k = 0; k < 4; k++) begin
            cmd(2'd2, 3'd0);
            load_cfg(int'(VECS[k].sel), VECS[k].h, VECS[k].tmax, VECS[k].n);
            load_x(VECS[k].x0, VECS[k].x1, VECS[k].x2, VECS[k].x3);
            cmd(2'd1, 3'd0);
            chk("R9 out after start", out_word, 32'h0);
            for (int s = 0; s < int'(VECS[k].n); s++) tick;
            chk("R5 out before completion", out_word, 32'h0);
            tick;
            chk("R5 completion word", out_word, 32'hFFFFFFFF);
            model(int'(VECS[k].sel), VECS[k].x0, VECS[k].x1, VECS[k].x2, VECS[k].x3,
                  VECS[k].h, VECS[k].tmax, int'(VECS[k].n));
            for (int i = 0; i < 4; i++) begin
                rd(i, v);
                chk("R3 R2 R1 R4 variable slot", v, exp_s[i]);
            end
            rd(4, v);
            chk("R3 R4 time slot", v, exp_s[4]);
        end

        // R5: step limit 0 completes on the first clock after start
        cfg_wr(18, 32'd0);
        cmd(2'd1, 3'd0);
        tick;
        chk("R5 zero limit", out_word, 32'hFFFFFFFF);

        // R6 R7 R11: reads ignored in RUN, write pauses ahead of the step
        cmd(2'd2, 3'd0);
        load_cfg(0, 32'h00004000, 32'h7F000000, 32'd100);
        load_x(32'h07000000, 32'h05000000, 32'h07000000, 32'h05000000);
        cmd(2'd1, 3'd0);
        tick;
        out_strobe = 1'b1; out_addr = 3'd0;
        tick;
        out_strobe = 1'b0;
        chk("R6 read ignored while running", out_word, 32'h0);
        tick;
        in_wr(4, 32'h00AB0000);
        repeat (3) tick;
        chk("R7 out zero after write", out_word, 32'h0);
        model(0, 32'h07000000, 32'h05000000, 32'h07000000, 32'h05000000,
              32'h00004000, 32'h7F000000, 3);
        rd(0, v); chk("R11 write beats step", v, exp_s[0]);
        repeat (3) tick;
        rd(0, v); chk("R7 paused after write", v, exp_s[0]);
        rd(4, v); chk("R7 written time slot", v, 32'h00AB0000);

        // R11 R8: restore beats a simultaneous write
        cmd_strobe = 1'b1; cmd_code = 2'd2; cmd_addr = 3'd0;
        in_strobe = 1'b1; in_addr = 3'd1; in_data = 32'h01000000;
        tick;
        cmd_strobe = 1'b0; in_strobe = 1'b0;
        rd(1, v); chk("R11 restore beats write", v, 32'h0);
        rd(4, v); chk("R8 restore clears time", v, 32'h0);

        // R10 R6: ignored commands, out-of-range read
        in_wr(2, 32'h00550000);
        rd(2, v); chk("R7 slot write readback", v, 32'h00550000);
        cmd(2'd1, 3'd1);
        chk("R10 start with nonzero address", out_word, 32'h00550000);
        cmd(2'd3, 3'd0);
        chk("R10 unused code", out_word, 32'h00550000);
        tick;
        chk("R6 idle hold", out_word, 32'h00550000);
        rd(6, v); chk("R6 read out of range", v, 32'h0);
        in_wr(5, 32'h12345678);
        rd(2, v); chk("R7 out-of-range write", v, 32'h00550000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule